// File: doc/BRIEF.md
# Breakpoint-Frozen Signature History Buffer

This block keeps a rolling record of per-cycle signatures produced elsewhere in a chip under debug. After it is armed, every cycle that carries a valid signature appends one entry to a circular store, and the oldest entry is overwritten once the store has wrapped. At the same time a comparator checks the live state vector against a programmed target. The comparison uses a mask, so only the selected bits take part. On a match the block stops recording and raises a breakpoint flag. The store then holds the signatures of the cycles that led up to the target state, ending with the signature of the matching cycle.

Once the buffer is frozen, a slow debug path reads the entries back one per request, oldest first. This lets offline analysis step backward from the breakpoint state one cycle at a time. The target and the mask are loaded serially through a shift chain. Re-arming clears the history so that a new run can be captured.

Top module: `sig_history_buf`

## Requirements
- R1: After reset, `bp_hit`, `rd_valid`, `rd_data` and `rd_count` are all zero and the block is not recording.
- R2: Each cycle with `cfg_shift` high shifts `cfg_bit` into the LSB of a 2×ST_W chain. Bits [2·ST_W-1:ST_W] of the chain are the target and bits [ST_W-1:0] are the mask. Sending the target MSB first and the mask LSB last programs both.
- R3: While recording, a cycle with `sig_valid` high stores `sig_data` as one new entry. A cycle with `sig_valid` low stores nothing, and `rd_count` stays unchanged.
- R4: The breakpoint condition is true when `state_vec` equals the target on every bit where the mask is 1. Bits where the mask is 0 are don't-care, so an all-zero mask matches on the first recording cycle.
- R5: On a matching recording cycle, any valid signature of that cycle is stored as the newest entry. `bp_hit` reads 1 from the next cycle onward, and recording stops. Signatures presented after that are not stored.
- R6: `rd_count` equals the number of stored entries, up to DEPTH. After more than DEPTH writes it stays at DEPTH, and the oldest entry is the one written DEPTH writes before the newest.
- R7: When the block is not recording, each cycle with `rd_req` high returns the next stored entry on `rd_data` one cycle later, with `rd_valid` high. Entries come oldest first. Once `rd_count` entries have been read, further requests return `rd_valid`=0 and `rd_data`=0.
- R8: A read request while recording is ignored. The next cycle shows `rd_valid`=0 and `rd_data`=0, and the read position does not advance.
- R9: A cycle with `arm` high starts recording and clears `bp_hit`, the stored count, the full state and the read position. No entry is written in that cycle.
- R10: The breakpoint never fires unless the block is recording. Before the first arm, a matching state leaves `bp_hit` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clear history and start recording |
| sig_valid | input | 1 | Signature on `sig_data` is valid this cycle |
| sig_data | input | SIG_W | Per-cycle signature |
| state_vec | input | ST_W | Monitored state bits |
| cfg_shift | input | 1 | Shift enable for the target/mask chain |
| cfg_bit | input | 1 | Serial configuration bit |
| bp_hit | output | 1 | Breakpoint reached, recording frozen |
| rd_req | input | 1 | Read the next stored entry |
| rd_data | output | SIG_W | Entry returned for the previous request |
| rd_valid | output | 1 | `rd_data` carries a stored entry |
| rd_count | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The breakpoint match and the signature write can fall in the same cycle, and the design has to keep the matching cycle's signature while refusing everything after it. The bench drives a valid signature together with the matching state in several runs. In some of these runs the same write also fills or wraps the ring. It then checks that the count includes that write, that one further valid signature after the hit leaves the count unchanged, and that the last entry read back equals the matching cycle's signature. A second overlap puts a read request inside a recording window. The bench judges it by the zero response and by the first read after the freeze still returning the oldest entry.

// File: rtl/sighb_pkg.sv
package sighb_pkg;
  // Modular add for ring indices; depth need not be a power of two.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned depth);
    int unsigned s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Number of live entries held in the ring.
  function automatic int unsigned live_count(logic full, int unsigned wptr, int unsigned depth);
    return full ? depth : wptr;
  endfunction

  // Index of the oldest live entry.
  function automatic int unsigned oldest_idx(logic full, int unsigned wptr);
    return full ? wptr : 0;
  endfunction
endpackage

// File: rtl/sighb_cfg_chain.sv
module sighb_cfg_chain #(
  parameter int ST_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [ST_W-1:0] target_o,
  output logic [ST_W-1:0] mask_o
);
  localparam int CHAIN_W = 2 * ST_W;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[CHAIN_W-2:0], bit_in};
  end

  assign target_o = chain_q[CHAIN_W-1:ST_W];
  assign mask_o   = chain_q[ST_W-1:0];
endmodule

// File: rtl/sighb_bp_cmp.sv
module sighb_bp_cmp #(
  parameter int ST_W = 8
) (
  input  logic [ST_W-1:0] state_i,
  input  logic [ST_W-1:0] target_i,
  input  logic [ST_W-1:0] mask_i,
  output logic            match_o
);
  logic [ST_W-1:0] miss;

  for (genvar b = 0; b < ST_W; b++) begin : g_bit
    assign miss[b] = mask_i[b] & (state_i[b] ^ target_i[b]);
  end

  assign match_o = (miss == '0);
endmodule

// File: rtl/sighb_ring.sv
module sighb_ring #(
  parameter int SIG_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [SIG_W-1:0]           wr_data,
  input  logic                       rd_en,
  input  logic                       rd_block,
  output logic [SIG_W-1:0]           rd_data,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import sighb_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [SIG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] rd_idx;
  logic             full;
  logic [PTR_W-1:0] rd_addr;
  logic [PTR_W-1:0] wr_next;
  logic             rd_fire;

  assign count   = CNT_W'(live_count(full, int'(wr_ptr), DEPTH));
  assign rd_addr = PTR_W'(ring_add(oldest_idx(full, int'(wr_ptr)), int'(rd_idx), DEPTH));
  assign wr_next = PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
  assign rd_fire = rd_en && !rd_block && (rd_idx < count);

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr   <= '0;
      full     <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) begin
        wr_ptr <= wr_next;
        if (wr_ptr == PTR_W'(DEPTH - 1)) full <= 1'b1;
      end
      if (rd_fire) begin
        rd_data  <= mem[rd_addr];
        rd_valid <= 1'b1;
        rd_idx   <= rd_idx + 1'b1;
      end else begin
        rd_data  <= '0;
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sig_history_buf.sv
module sig_history_buf #(
  parameter int SIG_W = 8,
  parameter int ST_W  = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       sig_valid,
  input  logic [SIG_W-1:0]           sig_data,
  input  logic [ST_W-1:0]            state_vec,
  input  logic                       cfg_shift,
  input  logic                       cfg_bit,
  output logic                       bp_hit,
  input  logic                       rd_req,
  output logic [SIG_W-1:0]           rd_data,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] rd_count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ST_W-1:0] tgt;
  logic [ST_W-1:0] msk;
  logic            bp_match;
  logic            rec_on;
  logic            wr_fire;

  sighb_cfg_chain #(.ST_W(ST_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift_en(cfg_shift), .bit_in(cfg_bit),
    .target_o(tgt), .mask_o(msk)
  );

  sighb_bp_cmp #(.ST_W(ST_W)) u_cmp (
    .state_i(state_vec), .target_i(tgt), .mask_i(msk), .match_o(bp_match)
  );

  assign wr_fire = rec_on && sig_valid && !arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_on <= 1'b0;
      bp_hit <= 1'b0;
    end else if (arm) begin
      rec_on <= 1'b1;
      bp_hit <= 1'b0;
    end else if (rec_on && bp_match) begin
      rec_on <= 1'b0;
      bp_hit <= 1'b1;
    end
  end

  sighb_ring #(.SIG_W(SIG_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(arm), .wr_en(wr_fire), .wr_data(sig_data),
    .rd_en(rd_req), .rd_block(rec_on), .rd_data(rd_data), .rd_valid(rd_valid),
    .count(rd_count)
  );
endmodule

// File: rtl/sighb_checker.sv
module sighb_checker #(
  parameter int SIG_W = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             sig_valid,
  input logic             rd_req,
  input logic             bp_hit,
  input logic             bp_match,
  input logic             rec_on,
  input logic             rd_valid,
  input logic [SIG_W-1:0] rd_data,
  input logic [CNT_W-1:0] rd_count
);
  // R5
  bp_follows_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_on && bp_match && !arm |=> bp_hit && !rec_on);
  // R5
  bp_stops_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bp_hit) |-> !rec_on);
  // R10
  no_bp_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_on && !bp_hit && !arm |=> !bp_hit);
  // R9
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !bp_hit && rec_on && rd_count == '0);
  // R8
  rd_during_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_on && rd_req |=> !rd_valid && rd_data == '0);
  // R3
  idle_sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_on && !sig_valid && !arm |=> $stable(rd_count));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CNT_W'(DEPTH));
  // R7
  rd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rec_on);
endmodule

bind sig_history_buf sighb_checker #(.SIG_W(SIG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .sig_valid(sig_valid), .rd_req(rd_req),
  .bp_hit(bp_hit), .bp_match(bp_match), .rec_on(rec_on), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_count(rd_count)
);

// File: tb/sig_history_buf_test.sv
module sig_history_buf_test;
  localparam int SW = 8, TW = 8, DP = 8;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, sig_valid = 1'b0, cfg_shift = 1'b0, cfg_bit = 1'b0, rd_req = 1'b0;
  logic [SW-1:0] sig_data = '0;
  logic [TW-1:0] state_vec = '0;
  logic bp_hit, rd_valid;
  logic [SW-1:0] rd_data;
  logic [CW-1:0] rd_count;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sig_history_buf #(.SIG_W(SW), .ST_W(TW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sig_valid(sig_valid), .sig_data(sig_data),
    .state_vec(state_vec), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit), .bp_hit(bp_hit),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .rd_count(rd_count)
  );

  // {mask, target, non-matching cycles before the match}
  localparam logic [23:0] VECS [5] = '{
    24'hFF_3C_03, 24'h0F_A5_07, 24'hF0_5A_0C, 24'h00_00_00, 24'h81_81_14
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic program_cfg(logic [TW-1:0] tg, logic [TW-1:0] mk);
    logic [2*TW-1:0] w;
    w = {tg, mk};
    for (int i = 2*TW-1; i >= 0; i--) begin
      cfg_shift = 1'b1; cfg_bit = w[i]; tick();
    end
    cfg_shift = 1'b0; cfg_bit = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1; tick(); arm = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 bp_hit", int'(bp_hit), 0);
    chk("R1 rd_count", int'(rd_count), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    rst_n = 1'b1; tick();

    // R10: matching state before any arm
    program_cfg(8'h42, 8'hFF);
    state_vec = 8'h42; sig_valid = 1'b1; sig_data = 8'h11;
    repeat (3) tick();
    chk("R10 bp_hit unarmed", int'(bp_hit), 0);
    chk("R10 count unarmed", int'(rd_count), 0);
    sig_valid = 1'b0;

    // Vector table: R2, R4, R5, R6, R7
    foreach (VECS[v]) begin
      logic [7:0] mk, tg, nw, lowb, nomatch, okstate;
      int cnt, first;
      {mk, tg, nw} = VECS[v];
      lowb    = mk & (~mk + 8'd1);
      okstate = tg ^ ~mk;
      nomatch = okstate ^ lowb;
      program_cfg(tg, mk);
      state_vec = nomatch;
      do_arm();
      for (int k = 0; k < int'(nw); k++) begin
        sig_valid = 1'b1; sig_data = 8'(v*40 + k); tick();
      end
      if (nw != 0) chk("R4 no hit on masked mismatch", int'(bp_hit), 0);
      sig_valid = 1'b1; sig_data = 8'(v*40 + int'(nw)); state_vec = okstate; tick();
      chk("R4 R2 hit on masked match", int'(bp_hit), 1);
      cnt = (int'(nw) + 1 < DP) ? int'(nw) + 1 : DP;
      chk("R6 count after freeze", int'(rd_count), cnt);
      sig_data = 8'hEE; tick();
      chk("R5 no write after hit", int'(rd_count), cnt);
      sig_valid = 1'b0;
      first = int'(nw) + 1 - cnt;
      for (int j = 0; j < cnt; j++) begin
        rd_req = 1'b1; tick();
        chk("R7 rd_valid", int'(rd_valid), 1);
        chk("R7 R6 entry oldest first", int'(rd_data), v*40 + first + j);
      end
      tick();
      chk("R7 read past end valid", int'(rd_valid), 0);
      chk("R7 read past end data", int'(rd_data), 0);
      rd_req = 1'b0; tick();
    end

    // R3 and R8: gated writes, read during recording
    program_cfg(8'h00, 8'hFF);
    state_vec = 8'hFF;
    do_arm();
    chk("R9 arm clears bp_hit", int'(bp_hit), 0);
    chk("R9 arm clears count", int'(rd_count), 0);
    sig_valid = 1'b1; sig_data = 8'h70; tick();
    sig_valid = 1'b0; sig_data = 8'h71; tick();
    chk("R3 no write without valid", int'(rd_count), 1);
    rd_req = 1'b1; tick();
    chk("R8 read while recording valid", int'(rd_valid), 0);
    chk("R8 read while recording data", int'(rd_data), 0);
    rd_req = 1'b0;
    sig_valid = 1'b1; sig_data = 8'h72; tick();
    sig_valid = 1'b0; state_vec = 8'h00; tick();
    chk("R5 hit with idle signature", int'(bp_hit), 1);
    chk("R3 count two", int'(rd_count), 2);
    rd_req = 1'b1; tick();
    chk("R8 read index not advanced", int'(rd_data), 8'h70);
    tick();
    chk("R3 second entry", int'(rd_data), 8'h72);
    rd_req = 1'b0;

    // R9 re-arm after freeze
    state_vec = 8'hFF; do_arm();
    chk("R9 rearm bp_hit", int'(bp_hit), 0);
    chk("R9 rearm count", int'(rd_count), 0);
    finish_run();
  end
endmodule